// File: doc/BRIEF.md
# Maskable Output Macrocell Bank

This block holds sixteen output macrocell flip-flops, arranged as two groups of eight. Programmable logic next to the bank supplies a next-state value and a load strobe for each cell. A host microcontroller bus can also overwrite a whole group with one write.

Each group has an 8-bit write-protect register. A set bit in it hides the matching cell from host writes, so logic-owned state, such as state machine bits, survives host traffic. A masked cell still loads from the logic side.

For each cell, an elaboration-time option chooses between two routings:
- **Pin output.** The cell drives a port pin. The driver's enable is the cell's enable term ORed with a host-programmable direction bit. A pin output built without an enable term has its driver on from reset.
- **Internal node.** The cell never drives the pin, which stays free for other I/O. Its value still goes back to the logic as feedback.

Top module: `macro_out_bank`

## Requirements
- R1: An active-low asynchronous reset clears every macrocell, both write-protect registers and both direction registers (all pins inputs). After reset, every readback address returns 0.
- R2: The host address map is as follows. Address 0 writes group 0 and address 1 writes group 1. Bit i of group g is cell g*8+i, which is bit g*8+i of `fb_out`. An unprotected cell takes the written bit on the clock edge of the write.
- R3: A host write leaves a cell unchanged when its protect bit is 1 and no logic load is present.
- R4: With no host write to its group, a cell whose `lgc_ld` bit is 1 takes the matching `lgc_next` bit on that edge. A cell with no load and no host write holds its value.
- R5: A host write and a logic load can reach a cell on the same edge. An unprotected cell then takes the host data, and a protected cell takes the logic value.
- R6: The protect registers are at address 2 (group 0) and address 3 (group 1). Both are writable and readable. The value 0x0F protects cells 0 to 3 of a group and leaves cells 4 to 7 writable.
- R7: For a pin-output cell that has an enable term, `pin_oe` is `oe_term` ORed with the cell's direction bit. The direction registers are at address 4 (group 0) and address 5 (group 1).
- R8: A pin-output cell built without an enable term (cells 0 to 3 by default) has `pin_oe` high from reset onward, whatever its `oe_term` and direction bits are.
- R9: An internal-node cell (cells 12 to 15 by default) holds `pin_oe` and `pin_out` at 0 whatever its term and direction bits are. Its value still appears on `fb_out`. A pin-output cell shows its value on `pin_out`.
- R10: Reads return the addressed register on `host_rdata` in the same cycle. Addresses 6 and above read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 4 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Readback of the addressed register |
| lgc_ld | input | 16 | Per-cell load strobe from the logic array |
| lgc_next | input | 16 | Per-cell next-state value from the logic array |
| oe_term | input | 16 | Per-pin enable term |
| pin_out | output | 16 | Pin data |
| pin_oe | output | 16 | Pin driver enable |
| fb_out | output | 16 | Feedback of every cell to the logic |

## Verification
Host writes are tried with protect masks of 0x00, 0x0F and 0xFF. This shows whether the mask acts per bit or on the whole group. The same-edge pattern combines a host write with a logic load on a partly protected group, so the result has bits from both sources and shows which source wins on each bit. Driver enables are tried with the term alone, the direction bit alone, neither, and both on internal cells. This separates the three generated pin variants. An asynchronous reset in the middle of the run shows that all registers clear, including the direction bits.

// File: rtl/mob_pkg.sv
package mob_pkg;

   // which register class a host address selects
   typedef enum logic [1:0] {
      SEL_CELL = 2'd0,
      SEL_MASK = 2'd1,
      SEL_DIR  = 2'd2,
      SEL_NONE = 2'd3
   } sel_e;

endpackage

// File: rtl/mob_host_regs.sv
// Write-protect and direction registers for one group
module mob_host_regs #(
   parameter int CELLS = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mask_we,
   input  logic             dir_we,
   input  logic [CELLS-1:0] wdata,
   output logic [CELLS-1:0] mask_q,
   output logic [CELLS-1:0] dir_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         dir_q  <= '0;
      end else begin
         if (mask_we) mask_q <= wdata;
         if (dir_we)  dir_q  <= wdata;
      end
   end

   assert_mask_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mask_we |=> (mask_q == $past(wdata)));

   assert_mask_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !mask_we |=> $stable(mask_q));

   assert_dir_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !dir_we |=> $stable(dir_q));

endmodule

// File: rtl/mob_cell_group.sv
// One group of output macrocells with per-bit host/logic arbitration
module mob_cell_group #(
   parameter int CELLS = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_hit,
   input  logic [CELLS-1:0] wdata,
   input  logic [CELLS-1:0] mask,
   input  logic [CELLS-1:0] ld,
   input  logic [CELLS-1:0] nxt,
   output logic [CELLS-1:0] cells
);

   logic [CELLS-1:0] host_take;

   assign host_take = wr_hit ? ~mask : '0;

   for (genvar i = 0; i < CELLS; i++) begin : g_cell
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)            cells[i] <= 1'b0;
         else if (host_take[i]) cells[i] <= wdata[i];
         else if (ld[i])        cells[i] <= nxt[i];
      end
   end

   assert_masked_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit |=> (((cells ^ $past(cells)) & $past(mask & ~ld)) == '0));

   assert_host_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit |=> (((cells ^ $past(wdata)) & $past(~mask)) == '0));

   assert_logic_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (((cells ^ $past(nxt)) & $past(ld & ~host_take)) == '0));

   assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_hit && ld == '0) |=> $stable(cells));

endmodule

// File: rtl/mob_pin_drive.sv
// Per-cell pin routing; the variant per cell is fixed at elaboration
module mob_pin_drive #(
   parameter int          N         = 16,
   parameter logic [N-1:0] PIN_MODE  = '1,
   parameter logic [N-1:0] TERM_USED = '1
) (
   input  logic [N-1:0] cells,
   input  logic [N-1:0] dir,
   input  logic [N-1:0] oe_term,
   output logic [N-1:0] pin_out,
   output logic [N-1:0] pin_oe
);

   for (genvar i = 0; i < N; i++) begin : g_pin
      if (PIN_MODE[i]) begin : g_port
         assign pin_out[i] = cells[i];
         if (TERM_USED[i]) begin : g_term
            assign pin_oe[i] = oe_term[i] | dir[i];
         end else begin : g_always
            assign pin_oe[i] = 1'b1;
         end
      end else begin : g_node
         assign pin_out[i] = 1'b0;
         assign pin_oe[i]  = 1'b0;
      end
   end

   logic unused_pin_inputs;
   assign unused_pin_inputs = ^{oe_term, dir};

endmodule

// File: rtl/macro_out_bank.sv
module macro_out_bank
   import mob_pkg::*;
#(
   parameter int GROUPS          = 2,
   parameter int CELLS_PER_GROUP = 8,
   parameter int ADDR_W          = 4,
   parameter logic [GROUPS*CELLS_PER_GROUP-1:0] PIN_MODE  = 16'h0FFF,
   parameter logic [GROUPS*CELLS_PER_GROUP-1:0] TERM_USED = 16'hFFF0
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              host_wr,
   input  logic [ADDR_W-1:0]                 host_addr,
   input  logic [CELLS_PER_GROUP-1:0]        host_wdata,
   output logic [CELLS_PER_GROUP-1:0]        host_rdata,
   input  logic [GROUPS*CELLS_PER_GROUP-1:0] lgc_ld,
   input  logic [GROUPS*CELLS_PER_GROUP-1:0] lgc_next,
   input  logic [GROUPS*CELLS_PER_GROUP-1:0] oe_term,
   output logic [GROUPS*CELLS_PER_GROUP-1:0] pin_out,
   output logic [GROUPS*CELLS_PER_GROUP-1:0] pin_oe,
   output logic [GROUPS*CELLS_PER_GROUP-1:0] fb_out
);

   localparam int N    = GROUPS * CELLS_PER_GROUP;
   localparam int GW   = (GROUPS > 1) ? $clog2(GROUPS) : 1;
   localparam int NREG = 3 * GROUPS;

   // elaboration-time parameter checks
   if (GROUPS < 1) begin : g_bad_groups
      $error("macro_out_bank: GROUPS must be at least 1");
   end
   if (CELLS_PER_GROUP < 1) begin : g_bad_cells
      $error("macro_out_bank: CELLS_PER_GROUP must be at least 1");
   end
   if (NREG > (1 << ADDR_W)) begin : g_bad_addr
      $error("macro_out_bank: ADDR_W too narrow for the register map");
   end

   // address decode: cells, then protect masks, then direction
   sel_e          sel;
   logic [GW-1:0] grp;

   always_comb begin
      sel = SEL_NONE;
      grp = '0;
      for (int g = 0; g < GROUPS; g++) begin
         if (host_addr == ADDR_W'(g)) begin
            sel = SEL_CELL;
            grp = GW'(g);
         end
         if (host_addr == ADDR_W'(GROUPS + g)) begin
            sel = SEL_MASK;
            grp = GW'(g);
         end
         if (host_addr == ADDR_W'(2 * GROUPS + g)) begin
            sel = SEL_DIR;
            grp = GW'(g);
         end
      end
   end

   logic [CELLS_PER_GROUP-1:0] cell_q [GROUPS];
   logic [CELLS_PER_GROUP-1:0] mask_q [GROUPS];
   logic [CELLS_PER_GROUP-1:0] dir_q  [GROUPS];
   logic [N-1:0]               dir_flat;
   logic [N-1:0]               cell_flat;

   for (genvar g = 0; g < GROUPS; g++) begin : g_grp
      logic hit;
      assign hit = host_wr && (grp == GW'(g));

      mob_host_regs #(
         .CELLS (CELLS_PER_GROUP)
      ) u_regs (
         .clk     (clk),
         .rst_n   (rst_n),
         .mask_we (hit && sel == SEL_MASK),
         .dir_we  (hit && sel == SEL_DIR),
         .wdata   (host_wdata),
         .mask_q  (mask_q[g]),
         .dir_q   (dir_q[g])
      );

      mob_cell_group #(
         .CELLS (CELLS_PER_GROUP)
      ) u_cells (
         .clk    (clk),
         .rst_n  (rst_n),
         .wr_hit (hit && sel == SEL_CELL),
         .wdata  (host_wdata),
         .mask   (mask_q[g]),
         .ld     (lgc_ld[g*CELLS_PER_GROUP +: CELLS_PER_GROUP]),
         .nxt    (lgc_next[g*CELLS_PER_GROUP +: CELLS_PER_GROUP]),
         .cells  (cell_q[g])
      );

      assign cell_flat[g*CELLS_PER_GROUP +: CELLS_PER_GROUP] = cell_q[g];
      assign dir_flat[g*CELLS_PER_GROUP +: CELLS_PER_GROUP]  = dir_q[g];
   end

   // readback, same cycle
   always_comb begin
      unique case (sel)
         SEL_CELL: host_rdata = cell_q[grp];
         SEL_MASK: host_rdata = mask_q[grp];
         SEL_DIR:  host_rdata = dir_q[grp];
         default:  host_rdata = '0;
      endcase
   end

   mob_pin_drive #(
      .N         (N),
      .PIN_MODE  (PIN_MODE),
      .TERM_USED (TERM_USED)
   ) u_pins (
      .cells   (cell_flat),
      .dir     (dir_flat),
      .oe_term (oe_term),
      .pin_out (pin_out),
      .pin_oe  (pin_oe)
   );

   assign fb_out = cell_flat;

   assert_node_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((pin_oe | pin_out) & ~PIN_MODE) == '0);

   assert_dir_enables_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((dir_flat & PIN_MODE) & ~pin_oe) == '0);

   assert_termless_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((PIN_MODE & ~TERM_USED) & ~pin_oe) == '0);

   assert_pin_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((pin_out ^ fb_out) & PIN_MODE) == '0);

endmodule

// File: tb/macro_out_bank_bench.sv
module macro_out_bank_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr = 1'b0;
   logic [3:0]  host_addr = '0;
   logic [7:0]  host_wdata = '0;
   logic [7:0]  host_rdata;
   logic [15:0] lgc_ld = '0;
   logic [15:0] lgc_next = '0;
   logic [15:0] oe_term = '0;
   logic [15:0] pin_out;
   logic [15:0] pin_oe;
   logic [15:0] fb_out;

   always #2 clk = ~clk;   // 250 MHz

   macro_out_bank u_macro_out_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_wr    (host_wr),
      .host_addr  (host_addr),
      .host_wdata (host_wdata),
      .host_rdata (host_rdata),
      .lgc_ld     (lgc_ld),
      .lgc_next   (lgc_next),
      .oe_term    (oe_term),
      .pin_out    (pin_out),
      .pin_oe     (pin_oe),
      .fb_out     (fb_out)
   );

   // observation kinds
   localparam int OBS_FB = 0, OBS_PIN = 1, OBS_OE = 2, OBS_RD = 3;

   typedef struct {
      string       req;
      int          obs;
      logic [15:0] exp;
   } item_t;

   item_t q[$];
   int    checks = 0;
   int    failures = 0;
   bit    done = 0;

   // monitor: compare every queued expectation at the falling edge
   always @(negedge clk) begin
      while (q.size() > 0) begin
         item_t       it;
         logic [15:0] act;
         it = q.pop_front();
         case (it.obs)
            OBS_FB:  act = fb_out;
            OBS_PIN: act = pin_out;
            OBS_OE:  act = pin_oe;
            default: act = {8'h00, host_rdata};
         endcase
         checks++;
         if (act !== it.exp) begin
            failures++;
            $display("FAIL %s obs=%0d actual=%h expected=%h", it.req, it.obs, act, it.exp);
         end
      end
   end

   task automatic expect_now(input int obs, input logic [15:0] exp, input string req);
      item_t it;
      it.req = req;
      it.obs = obs;
      it.exp = exp;
      q.push_back(it);
      @(negedge clk);
      #1;
   endtask

   task automatic host_write(input logic [3:0] a, input logic [7:0] d);
      @(posedge clk);
      #1;
      host_wr    = 1'b1;
      host_addr  = a;
      host_wdata = d;
      @(posedge clk);
      #1;
      host_wr = 1'b0;
   endtask

   task automatic rd_chk(input logic [3:0] a, input logic [7:0] e, input string req);
      host_addr = a;
      expect_now(OBS_RD, {8'h00, e}, req);
   endtask

   initial begin
      #(4 * 100000);
      if (!done) begin
         done = 1;
         failures++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R1 / R8: state during reset
      expect_now(OBS_FB, 16'h0000, "R1");
      expect_now(OBS_OE, 16'h000F, "R8");
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      for (int a = 0; a < 6; a++) rd_chk(4'(a), 8'h00, "R1");

      // R2: unprotected host writes
      host_write(4'd0, 8'hA5);
      expect_now(OBS_FB, 16'h00A5, "R2");
      host_write(4'd1, 8'h3C);
      expect_now(OBS_FB, 16'h3CA5, "R2");
      rd_chk(4'd0, 8'hA5, "R2");
      rd_chk(4'd1, 8'h3C, "R2");

      // R6 / R3: protect low nibble of group 0
      host_write(4'd2, 8'h0F);
      rd_chk(4'd2, 8'h0F, "R6");
      host_write(4'd0, 8'hFF);
      expect_now(OBS_FB, 16'h3CF5, "R3");
      host_write(4'd0, 8'h00);
      expect_now(OBS_FB, 16'h3C05, "R3");

      // R4: logic load with no host write
      @(posedge clk);
      #1;
      lgc_ld   = 16'h00FF;
      lgc_next = 16'h000A;
      @(posedge clk);
      #1;
      lgc_ld = '0;
      lgc_next = 16'hFFFF;
      expect_now(OBS_FB, 16'h3C0A, "R4");
      @(posedge clk);
      #1;
      expect_now(OBS_FB, 16'h3C0A, "R4");

      // R5: same-edge host write and logic load, mask 0x0F
      @(posedge clk);
      #1;
      host_wr = 1'b1; host_addr = 4'd0; host_wdata = 8'hF0;
      lgc_ld = 16'h00FF; lgc_next = 16'h0003;
      @(posedge clk);
      #1;
      host_wr = 1'b0; lgc_ld = '0;
      expect_now(OBS_FB, 16'h3CF3, "R5");

      // R5: fully protected group 1 takes only the logic value
      host_write(4'd3, 8'hFF);
      rd_chk(4'd3, 8'hFF, "R6");
      @(posedge clk);
      #1;
      host_wr = 1'b1; host_addr = 4'd1; host_wdata = 8'h00;
      lgc_ld = 16'hFF00; lgc_next = 16'h8100;
      @(posedge clk);
      #1;
      host_wr = 1'b0; lgc_ld = '0;
      expect_now(OBS_FB, 16'h81F3, "R5");

      // R9: pin data only for pin cells, feedback keeps all
      expect_now(OBS_PIN, 16'h01F3, "R9");

      // R7 / R8 / R9: enable terms and direction bits
      host_write(4'd4, 8'h30);
      oe_term = 16'h2143;
      expect_now(OBS_OE, 16'h017F, "R7");
      host_write(4'd5, 8'hFF);
      expect_now(OBS_OE, 16'h0F7F, "R9");
      oe_term = 16'h0000;
      expect_now(OBS_OE, 16'h0F3F, "R7");

      // R10: readback of direction and unmapped addresses
      rd_chk(4'd4, 8'h30, "R10");
      rd_chk(4'd5, 8'hFF, "R10");
      rd_chk(4'd7, 8'h00, "R10");
      rd_chk(4'd15, 8'h00, "R10");

      // R1: asynchronous reset mid-run
      @(posedge clk);
      #1;
      rst_n = 1'b0;
      expect_now(OBS_FB, 16'h0000, "R1");
      rd_chk(4'd2, 8'h00, "R1");
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      rd_chk(4'd5, 8'h00, "R1");
      expect_now(OBS_OE, 16'h000F, "R8");

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule